// File: doc/BRIEF.md
# Reset Type Selector and Start-up Sequencer

This block sits between the chip's reset sources and the CPU. It watches an active-low power-on reset pin, an active-low manual reset pin and a watchdog overflow strobe. From these it picks a reset type, power-on or manual, and holds the matching reset domains. A power-on reset clears the CPU with its interrupt controller, the on-chip peripherals and the pin-function/I/O-port logic. A manual reset clears only the CPU and interrupt controller. The power-on pin is debounced by length: a low level counts only once it has been sampled for `MIN_LOW` consecutive clocks.

When the reset is released, the block runs the CPU start-up sequence. It reads the initial program counter and then the initial stack pointer from the vector table over a request/ready read port. It then presents a cleared vector base and an all-ones interrupt mask, and releases the CPU with a one-cycle done pulse. A new reset request arriving at any point before or after release takes over at once. The sequence starts again with the new type.

A separate active-low `sys_rst_n` clears only the sequencer's own flops while the supply ramps. After it, the CPU stays held until a valid power-on pulse has been seen.

Top module: `reset_sequencer`

## Requirements
- R1: After `sys_rst_n` is released, `cpu_rst`, `periph_rst` and `port_rst` are 1, and `mem_req` and `cpu_run` are 0. Manual or watchdog requests do not leave this state; only a valid power-on pulse does.
- R2: A low level on `pwr_rst_n` is accepted only at the clock edge that samples it low for the 20th (`MIN_LOW`) consecutive time. A pulse sampled low 19 times leaves a running CPU running and issues no vector read.
- R3: During a power-on reset, `periph_rst` and `port_rst` are 1 together with `cpu_rst`. During a manual reset, `cpu_rst` is 1 and both of the others stay 0.
- R4: An accepted power-on low overrides a manual reset already in progress. `periph_rst` rises at the edge that accepts it, and the later reads use the power-on vectors.
- R5: With `pwr_rst_n` high, `man_rst_n` sampled low puts the CPU into reset at that edge. Start-up begins once both pins are high.
- R6: A one-cycle `wdt_ovf` with both pins high starts the sequence at once. `wdt_kind`=1 selects a power-on reset and `wdt_kind`=0 selects a manual reset.
- R7: Start-up first reads the PC word at the type's vector base, then the SP word at base+4. The bases are 0x0 for power-on and 0x8 for manual. `mem_req` and `mem_addr` hold steady until `mem_ready` is sampled high.
- R8: After the SP read, `pc_init` and `sp_init` hold the two fetched words, `vbr_init` is 0x00000000 and `sr_imask` is 4'b1111. Then `cpu_run` rises and `seq_done` is high for exactly that first run cycle.
- R9: A reset request arriving during the vector reads restarts the sequence from the PC read, with the newly selected type.
- R10: `stat_por` is 1 when the latest reset was of power-on type. `stat_wdt` is 1 when the watchdog caused it and 0 when a pin did.
- R11: A reset request seen while running drops `cpu_run` at the sampling edge, so the CPU is halted from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Asynchronous clear of the sequencer's own flops, active low |
| pwr_rst_n | input | 1 | Power-on reset pin, active low, synchronous |
| man_rst_n | input | 1 | Manual reset pin, active low, synchronous |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| wdt_kind | input | 1 | Type requested by the watchdog: 1 power-on, 0 manual |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | AW | Vector byte address |
| mem_ready | input | 1 | Read data valid, completes the request |
| mem_rdata | input | DW | Read data |
| cpu_rst | output | 1 | CPU and interrupt controller reset |
| periph_rst | output | 1 | On-chip peripheral reset |
| port_rst | output | 1 | Pin-function and I/O port reset |
| cpu_run | output | 1 | CPU released to execute |
| seq_done | output | 1 | One-cycle pulse on release |
| pc_init | output | DW | Fetched initial program counter |
| sp_init | output | DW | Fetched initial stack pointer |
| vbr_init | output | DW | Vector base value to load |
| sr_imask | output | 4 | Interrupt mask value to load |
| stat_por | output | 1 | Last reset was of power-on type |
| stat_wdt | output | 1 | Last reset came from the watchdog |

## Verification
The bench drives a 19-sample and a 20-sample low on the power-on pin. A filter that is off by one either halts a running CPU on a glitch or misses a legal reset. It holds the manual pin low and then asserts the power-on pin; a design with the wrong priority would keep the peripherals out of reset and read the manual vectors. It fires a watchdog strobe while the PC read is stalled; a design that does not restart would finish the stale read at 0x8 and load the wrong PC. Each start-up is also checked for the exact read order, the mask and base values, and a done pulse of one cycle.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MIN_LOW = 20,
  parameter logic [AW-1:0] POR_VEC = '0,
  parameter logic [AW-1:0] MAN_VEC = AW'(8)
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          pwr_rst_n,
  input  logic          man_rst_n,
  input  logic          wdt_ovf,
  input  logic          wdt_kind,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_rst,
  output logic          periph_rst,
  output logic          port_rst,
  output logic          cpu_run,
  output logic          seq_done,
  output logic [DW-1:0] pc_init,
  output logic [DW-1:0] sp_init,
  output logic [DW-1:0] vbr_init,
  output logic [3:0]    sr_imask,
  output logic          stat_por,
  output logic          stat_wdt
);
  localparam int CW = $clog2(MIN_LOW + 1);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_PC, S_SP, S_INIT, S_RUN} st_t;

  st_t st, nxt;
  logic [CW-1:0] lowcnt;
  logic kind_por, kind_wdt, nk_por, nk_wdt;
  logic por_now, man_now, wdt_now;

  assign por_now = !pwr_rst_n && (lowcnt >= CW'(MIN_LOW - 1));
  assign man_now = pwr_rst_n && !man_rst_n;
  assign wdt_now = pwr_rst_n && man_rst_n && wdt_ovf;

  always_comb begin
    nxt = st;
    nk_por = kind_por;
    nk_wdt = kind_wdt;
    case (st)
      S_OFF: if (por_now) begin nxt = S_HOLD; nk_por = 1'b1; nk_wdt = 1'b0; end
      S_HOLD: begin
        if (kind_por) begin
          if (pwr_rst_n) nxt = S_PC;
        end else if (por_now) begin
          nk_por = 1'b1;
          nk_wdt = 1'b0;
        end else if (pwr_rst_n && man_rst_n) begin
          nxt = S_PC;
        end
      end
      default: begin
        if (por_now) begin
          nxt = S_HOLD; nk_por = 1'b1; nk_wdt = 1'b0;
        end else if (man_now) begin
          nxt = S_HOLD; nk_por = 1'b0; nk_wdt = 1'b0;
        end else if (wdt_now) begin
          nxt = S_PC; nk_por = wdt_kind; nk_wdt = 1'b1;
        end else begin
          case (st)
            S_PC:   if (mem_ready) nxt = S_SP;
            S_SP:   if (mem_ready) nxt = S_INIT;
            S_INIT: nxt = S_RUN;
            default: nxt = st;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      st <= S_OFF;
      lowcnt <= '0;
      kind_por <= 1'b1;
      kind_wdt <= 1'b0;
      pc_init <= '0;
      sp_init <= '0;
      vbr_init <= '1;
      sr_imask <= '0;
      seq_done <= 1'b0;
    end else begin
      st <= nxt;
      kind_por <= nk_por;
      kind_wdt <= nk_wdt;
      if (pwr_rst_n) lowcnt <= '0;
      else if (lowcnt != CW'(MIN_LOW)) lowcnt <= lowcnt + 1'b1;
      if (st == S_PC && nxt == S_SP) pc_init <= mem_rdata;
      if (st == S_SP && nxt == S_INIT) sp_init <= mem_rdata;
      if (st == S_INIT && nxt == S_RUN) begin
        vbr_init <= '0;
        sr_imask <= 4'hF;
      end
      seq_done <= (st == S_INIT) && (nxt == S_RUN);
    end
  end

  assign mem_req = (st == S_PC) || (st == S_SP);
  assign mem_addr = (kind_por ? POR_VEC : MAN_VEC) + ((st == S_SP) ? AW'(4) : '0);
  assign cpu_run = (st == S_RUN);
  assign cpu_rst = !cpu_run;
  assign periph_rst = cpu_rst && kind_por;
  assign port_rst = cpu_rst && kind_por;
  assign stat_por = kind_por;
  assign stat_wdt = kind_wdt;

  a_r7_req_held: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (mem_req && !mem_ready && pwr_rst_n && man_rst_n && !wdt_ovf) |=> (mem_req && $stable(mem_addr)));

  a_r8_init_values: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(cpu_run) |-> (vbr_init == '0 && sr_imask == 4'hF && seq_done));

  a_r8_done_once: assert property (@(posedge clk) disable iff (!sys_rst_n)
    seq_done |=> !seq_done);

  a_r11_man_halts: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cpu_run && pwr_rst_n && !man_rst_n) |=> (!cpu_run && !periph_rst));

  a_r6_wdt_starts: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (cpu_run && pwr_rst_n && man_rst_n && wdt_ovf) |=> (mem_req && stat_wdt && stat_por == $past(wdt_kind)));

  a_r4_por_over_man: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (st == S_HOLD && !pwr_rst_n && lowcnt == CW'(MIN_LOW - 1)) |=> (periph_rst && port_rst && cpu_rst));
endmodule

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
  logic clk = 1'b0;
  logic sys_rst_n, pwr_rst_n, man_rst_n, wdt_ovf, wdt_kind;
  logic mem_req, mem_ready;
  logic [31:0] mem_addr, mem_rdata;
  logic cpu_rst, periph_rst, port_rst, cpu_run, seq_done;
  logic [31:0] pc_init, sp_init, vbr_init;
  logic [3:0] sr_imask;
  logic stat_por, stat_wdt;

  int checks = 0;
  int fails = 0;
  int lat = 1;
  int wcnt = 0;
  int nlog = 0;
  logic [31:0] alog [0:7];

  always #10 clk = ~clk;

  reset_sequencer dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .pwr_rst_n(pwr_rst_n), .man_rst_n(man_rst_n),
    .wdt_ovf(wdt_ovf), .wdt_kind(wdt_kind), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .cpu_rst(cpu_rst), .periph_rst(periph_rst),
    .port_rst(port_rst), .cpu_run(cpu_run), .seq_done(seq_done), .pc_init(pc_init),
    .sp_init(sp_init), .vbr_init(vbr_init), .sr_imask(sr_imask), .stat_por(stat_por),
    .stat_wdt(stat_wdt));

  function automatic logic [31:0] vec(input logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0111) ^ 32'h0000_5A00;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= vec(mem_addr);
        if (nlog < 8) alog[nlog] = mem_addr;
        nlog = nlog + 1;
        wcnt = 0;
      end else begin
        mem_ready <= 1'b0;
        wcnt = wcnt + 1;
      end
    end else begin
      mem_ready <= 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_startup(input logic [31:0] base, input bit por, input bit wdt);
    int dones = 0;
    int guard = 0;
    while (!cpu_run && guard < 300) begin
      @(negedge clk);
      if (seq_done) dones++;
      guard++;
    end
    repeat (3) begin
      @(negedge clk);
      if (seq_done) dones++;
    end
    chk(cpu_run, "R8 cpu released", 32'(cpu_run), 1);
    chk(nlog == 2, "R7 read count", 32'(nlog), 2);
    chk(alog[0] == base, "R7 first read at PC vector", alog[0], base);
    chk(alog[1] == base + 4, "R7 second read at SP vector", alog[1], base + 4);
    chk(pc_init == vec(base), "R8 pc_init", pc_init, vec(base));
    chk(sp_init == vec(base + 4), "R8 sp_init", sp_init, vec(base + 4));
    chk(vbr_init == 32'h0, "R8 vbr_init cleared", vbr_init, 0);
    chk(sr_imask == 4'hF, "R8 sr_imask set", 32'(sr_imask), 32'hF);
    chk(dones == 1, "R8 single done pulse", 32'(dones), 1);
    chk(stat_por == por, "R10 stat_por", 32'(stat_por), 32'(por));
    chk(stat_wdt == wdt, "R10 stat_wdt", 32'(stat_wdt), 32'(wdt));
    chk(!cpu_rst && !periph_rst && !port_rst, "R8 resets released", {cpu_rst, periph_rst, port_rst}, 0);
  endtask

  task automatic t_reset_state();
    sys_rst_n = 1'b0; pwr_rst_n = 1'b1; man_rst_n = 1'b1; wdt_ovf = 1'b0; wdt_kind = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_rst && periph_rst && port_rst, "R1 resets after clear", {cpu_rst, periph_rst, port_rst}, 3'b111);
    chk(!mem_req && !cpu_run, "R1 idle after clear", {mem_req, cpu_run}, 0);
    man_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    man_rst_n = 1'b1;
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    repeat (4) @(negedge clk);
    chk(!mem_req && !cpu_run && cpu_rst, "R1 manual and watchdog ignored before power-on", {mem_req, cpu_run, cpu_rst}, 3'b001);
  endtask

  task automatic t_power_on(input int lat_i);
    bit running = cpu_run;
    lat = lat_i;
    nlog = 0;
    pwr_rst_n = 1'b0;
    repeat (19) @(negedge clk);
    if (running) chk(cpu_run, "R2 still running before 20th low sample", 32'(cpu_run), 1);
    @(negedge clk);
    chk(cpu_rst && periph_rst && port_rst, "R3 power-on asserts all domains", {cpu_rst, periph_rst, port_rst}, 3'b111);
    repeat (5) @(negedge clk);
    chk(!mem_req, "R7 no read while pin low", 32'(mem_req), 0);
    pwr_rst_n = 1'b1;
    run_startup(32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_short_pulse();
    bit stayed = 1'b1;
    nlog = 0;
    pwr_rst_n = 1'b0;
    repeat (19) begin
      @(negedge clk);
      if (!cpu_run || mem_req) stayed = 1'b0;
    end
    pwr_rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (!cpu_run || mem_req) stayed = 1'b0;
    end
    chk(stayed, "R2 19-sample pulse ignored", 32'(stayed), 1);
    chk(nlog == 0, "R2 no vector read after short pulse", 32'(nlog), 0);
  endtask

  task automatic t_manual();
    lat = 2;
    nlog = 0;
    man_rst_n = 1'b0;
    @(negedge clk);
    chk(!cpu_run && cpu_rst, "R11 run drops one edge after request", {cpu_run, cpu_rst}, 2'b01);
    chk(!periph_rst && !port_rst, "R3 manual leaves peripherals and ports", {periph_rst, port_rst}, 0);
    repeat (3) @(negedge clk);
    chk(!mem_req && cpu_rst, "R5 held while manual pin low", {mem_req, cpu_rst}, 2'b01);
    man_rst_n = 1'b1;
    run_startup(32'h8, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    lat = 0;
    nlog = 0;
    man_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    pwr_rst_n = 1'b0;
    repeat (19) @(negedge clk);
    chk(!periph_rst, "R4 peripherals untouched before acceptance", 32'(periph_rst), 0);
    @(negedge clk);
    chk(periph_rst && port_rst, "R4 power-on overrides manual", {periph_rst, port_rst}, 2'b11);
    repeat (2) @(negedge clk);
    pwr_rst_n = 1'b1;
    man_rst_n = 1'b1;
    run_startup(32'h0, 1'b1, 1'b0);
  endtask

  task automatic t_wdt(input bit kind);
    lat = 1;
    nlog = 0;
    wdt_kind = kind;
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    chk(mem_req && !cpu_run, "R6 watchdog starts reads at once", {mem_req, cpu_run}, 2'b10);
    chk(periph_rst == kind, "R6 watchdog type selects domains", 32'(periph_rst), 32'(kind));
    run_startup(kind ? 32'h0 : 32'h8, kind, 1'b1);
  endtask

  task automatic t_restart();
    lat = 6;
    man_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    man_rst_n = 1'b1;
    nlog = 0;
    repeat (2) @(negedge clk);
    chk(mem_req && mem_addr == 32'h8, "R9 manual PC read pending", mem_addr, 32'h8);
    wdt_kind = 1'b1;
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    chk(mem_req && mem_addr == 32'h0, "R9 restarted at power-on PC vector", mem_addr, 32'h0);
    run_startup(32'h0, 1'b1, 1'b1);
  endtask

  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    t_reset_state();
    t_power_on(2);
    t_short_pulse();
    t_manual();
    t_priority();
    t_wdt(1'b0);
    t_wdt(1'b1);
    t_restart();
    t_power_on(0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule